// File: doc/BRIEF.md
# RTC Seconds Counter with Alarm

This block is a register-mapped real-time-clock core. A sub-second prescaler counts enable strobes from an oscillator domain that has already been synchronised, and emits a one-cycle second pulse every `CAL + 1` strobes, where `CAL` is a programmable calibration value. Each second pulse advances a 32-bit seconds counter. The counter is compared against a 32-bit alarm value.

Software loads a new time by writing a set-time register. The value does not reach the current-time register right away. It is held pending and is copied in at the next second pulse. Until that pulse, the pending value can only be read back through a separate set-time readback register. Software uses the seconds status bit to tell which of the two registers holds the valid time. Writing the calibration register restarts the prescaler, so the first pulse after the write arrives one full second later.

There are two interrupt sources: the seconds event and the alarm event. Each has a sticky status bit that is cleared by writing a 1, and an enable bit. The enable bit is set through one register, cleared through another, and read back through a mask register. Each source drives its own interrupt output. Register reads return data one cycle after the read strobe.

Top module: `rtc_sec_core`

## Requirements
- R1: Byte offsets: 0x00 set-time write, 0x04 set-time readback, 0x08 calibration write, 0x0C calibration readback, 0x10 current seconds, 0x14 sub-second tick (bits 15:0), 0x18 alarm (read/write), 0x20 status, 0x24 mask, 0x28 enable, 0x2C disable, 0x40 control. Any other offset reads 0. Read data appears on `bus_rdata` one cycle after `bus_rd`.
- R2: A set-time write leaves the current-time register unchanged until the next second pulse. At that pulse the written value is copied in. The set-time readback register returns the last written value.
- R3: When no load is pending, every second pulse increments the seconds count by one. The count wraps from 0xFFFFFFFF to 0.
- R4: The tick counter counts enable strobes from 0 up to CAL. On the strobe that finds it at CAL, it returns to 0 and a second pulse follows on the next cycle.
- R5: A calibration write stores CAL and clears the tick counter in the same cycle. The next second pulse therefore comes CAL+1 strobes later.
- R6: Status bit 0 is set at each second update. Status bit 1 is set at the update in which the new seconds value equals the alarm. Both bits set whether or not their source is enabled.
- R7: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged. A new event in the same cycle wins over the clear.
- R8: Writing 1 to bit i of the enable register enables source i. Writing 1 to bit i of the disable register disables it. The mask register reads the enables back (bit 0 seconds, bit 1 alarm).
- R9: `irq_sec` is high exactly when status bit 0 and its enable are both set. `irq_alarm` follows the same rule for bit 1.
- R10: The alarm event fires at the second update that makes the seconds value equal the alarm register. This includes an update caused by a pending time load.
- R11: Control bit 31 (battery-switch enable) and bit 24 (oscillator enable) are plain read/write bits. All other control bits read 0.
- R12: Reset clears the seconds count, the pending load, the tick counter, status, enables and control bits, and sets CAL to the `CAL_RESET` parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and core clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Sub-second oscillator strobe, one cycle per tick |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_sec | output | 1 | Seconds interrupt |
| irq_alarm | output | 1 | Alarm interrupt |

## Verification
The checker watches four rules on every cycle. The seconds count changes only on a second pulse, and steps by exactly one when no load is pending. The tick counter never exceeds CAL and is zero after a calibration write. Both status bits follow their events, and a write-1 clear takes effect. The exact second boundary that delivers a pending load, the period of the second pulse for each CAL value, the wrap of the count, and the cycle on which the alarm interrupt rises can only be shown by the bench's timed scenarios. Those scenarios compare register reads against the arithmetic timeline that a calibration write starts.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;
  localparam int DATA_W = 32;

  // register byte offsets
  localparam int OFF_SET_WR  = 'h00;
  localparam int OFF_SET_RD  = 'h04;
  localparam int OFF_CAL_WR  = 'h08;
  localparam int OFF_CAL_RD  = 'h0C;
  localparam int OFF_CUR_SEC = 'h10;
  localparam int OFF_TICK    = 'h14;
  localparam int OFF_ALARM   = 'h18;
  localparam int OFF_STATUS  = 'h20;
  localparam int OFF_MASK    = 'h24;
  localparam int OFF_ENABLE  = 'h28;
  localparam int OFF_DISABLE = 'h2C;
  localparam int OFF_CTRL    = 'h40;

  // interrupt sources, bit positions in status/mask/enable/disable
  localparam int NSRC    = 2;
  localparam int SRC_SEC = 0;
  localparam int SRC_ALM = 1;

  // control bit positions
  localparam int CTRL_BATT_BIT = 31;
  localparam int CTRL_OSC_BIT  = 24;
endpackage

// File: rtl/rtc_prescaler.sv
`timescale 1ns/1ps
module rtc_prescaler #(
  parameter int TICK_W    = 16,
  parameter int CAL_RESET = 32767
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              cal_wr,
  input  logic [TICK_W-1:0] cal_wdata,
  output logic [TICK_W-1:0] cal_q,
  output logic [TICK_W-1:0] cnt_q,
  output logic              sec_pulse
);
  localparam logic [TICK_W-1:0] CAL_INIT = TICK_W'(CAL_RESET);

  always_ff @(posedge clk) begin
    if (rst) begin
      cal_q     <= CAL_INIT;
      cnt_q     <= '0;
      sec_pulse <= 1'b0;
    end else begin
      sec_pulse <= 1'b0;
      if (cal_wr) begin
        // restart the second so the next pulse is a full period away
        cal_q <= cal_wdata;
        cnt_q <= '0;
      end else if (tick_en) begin
        if (cnt_q == cal_q) begin
          cnt_q     <= '0;
          sec_pulse <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rtc_timekeeper.sv
`timescale 1ns/1ps
module rtc_timekeeper #(
  parameter int SEC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sec_pulse,
  input  logic             set_wr,
  input  logic             alarm_wr,
  input  logic [SEC_W-1:0] wdata,
  output logic [SEC_W-1:0] cur_q,
  output logic [SEC_W-1:0] set_q,
  output logic [SEC_W-1:0] alarm_q,
  output logic             load_pend,
  output logic             alarm_hit
);
  logic [SEC_W-1:0] next_sec;

  // value the count takes at the coming second boundary
  assign next_sec  = load_pend ? set_q : cur_q + 1'b1;
  assign alarm_hit = sec_pulse && (next_sec == alarm_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q     <= '0;
      set_q     <= '0;
      alarm_q   <= '0;
      load_pend <= 1'b0;
    end else begin
      if (sec_pulse) begin
        cur_q     <= next_sec;
        load_pend <= 1'b0;
      end
      if (set_wr) begin
        set_q     <= wdata;
        load_pend <= 1'b1;
      end
      if (alarm_wr) alarm_q <= wdata;
    end
  end
endmodule

// File: rtl/rtc_irq_ctrl.sv
`timescale 1ns/1ps
module rtc_irq_ctrl #(
  parameter int NSRC = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] event_i,
  input  logic            sts_wr,
  input  logic            en_wr,
  input  logic            dis_wr,
  input  logic [NSRC-1:0] wdata,
  output logic [NSRC-1:0] status_q,
  output logic [NSRC-1:0] enable_q,
  output logic [NSRC-1:0] irq
);
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst) begin
        status_q[i] <= 1'b0;
        enable_q[i] <= 1'b0;
      end else begin
        if (event_i[i])                  status_q[i] <= 1'b1;
        else if (sts_wr && wdata[i])     status_q[i] <= 1'b0;
        if (en_wr && wdata[i])           enable_q[i] <= 1'b1;
        else if (dis_wr && wdata[i])     enable_q[i] <= 1'b0;
      end
    end
    assign irq[i] = status_q[i] & enable_q[i];
  end
endmodule

// File: rtl/rtc_sec_core.sv
`timescale 1ns/1ps
module rtc_sec_core #(
  parameter int ADDR_W    = 7,
  parameter int TICK_W    = 16,
  parameter int CAL_RESET = 32767
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_sec,
  output logic              irq_alarm
);
  import rtc_pkg::*;

  localparam int PAD_W = DATA_W - TICK_W;
  localparam int SRC_PAD = DATA_W - NSRC;

  logic              wr_set, wr_cal, wr_alarm, wr_sts, wr_en, wr_dis, wr_ctrl;
  logic [TICK_W-1:0] cal_val, tick_cnt;
  logic              sec_pulse, load_pend, alarm_hit;
  logic [31:0]       cur_sec, set_sec, alarm_sec;
  logic [NSRC-1:0]   irq_status, irq_enable, irq_vec, irq_events;
  logic              ctrl_batt, ctrl_osc;

  assign wr_set   = bus_wr && (bus_addr == ADDR_W'(OFF_SET_WR));
  assign wr_cal   = bus_wr && (bus_addr == ADDR_W'(OFF_CAL_WR));
  assign wr_alarm = bus_wr && (bus_addr == ADDR_W'(OFF_ALARM));
  assign wr_sts   = bus_wr && (bus_addr == ADDR_W'(OFF_STATUS));
  assign wr_en    = bus_wr && (bus_addr == ADDR_W'(OFF_ENABLE));
  assign wr_dis   = bus_wr && (bus_addr == ADDR_W'(OFF_DISABLE));
  assign wr_ctrl  = bus_wr && (bus_addr == ADDR_W'(OFF_CTRL));

  rtc_prescaler #(.TICK_W(TICK_W), .CAL_RESET(CAL_RESET)) u_presc (
    .clk       (clk),
    .rst       (rst),
    .tick_en   (tick_en),
    .cal_wr    (wr_cal),
    .cal_wdata (bus_wdata[TICK_W-1:0]),
    .cal_q     (cal_val),
    .cnt_q     (tick_cnt),
    .sec_pulse (sec_pulse)
  );

  rtc_timekeeper #(.SEC_W(DATA_W)) u_time (
    .clk       (clk),
    .rst       (rst),
    .sec_pulse (sec_pulse),
    .set_wr    (wr_set),
    .alarm_wr  (wr_alarm),
    .wdata     (bus_wdata),
    .cur_q     (cur_sec),
    .set_q     (set_sec),
    .alarm_q   (alarm_sec),
    .load_pend (load_pend),
    .alarm_hit (alarm_hit)
  );

  always_comb begin
    irq_events          = '0;
    irq_events[SRC_SEC] = sec_pulse;
    irq_events[SRC_ALM] = alarm_hit;
  end

  rtc_irq_ctrl #(.NSRC(NSRC)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .event_i  (irq_events),
    .sts_wr   (wr_sts),
    .en_wr    (wr_en),
    .dis_wr   (wr_dis),
    .wdata    (bus_wdata[NSRC-1:0]),
    .status_q (irq_status),
    .enable_q (irq_enable),
    .irq      (irq_vec)
  );

  assign irq_sec   = irq_vec[SRC_SEC];
  assign irq_alarm = irq_vec[SRC_ALM];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_batt <= 1'b0;
      ctrl_osc  <= 1'b0;
    end else if (wr_ctrl) begin
      ctrl_batt <= bus_wdata[CTRL_BATT_BIT];
      ctrl_osc  <= bus_wdata[CTRL_OSC_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        ADDR_W'(OFF_SET_RD):  bus_rdata <= set_sec;
        ADDR_W'(OFF_CAL_RD):  bus_rdata <= {{PAD_W{1'b0}}, cal_val};
        ADDR_W'(OFF_CUR_SEC): bus_rdata <= cur_sec;
        ADDR_W'(OFF_TICK):    bus_rdata <= {{PAD_W{1'b0}}, tick_cnt};
        ADDR_W'(OFF_ALARM):   bus_rdata <= alarm_sec;
        ADDR_W'(OFF_STATUS):  bus_rdata <= {{SRC_PAD{1'b0}}, irq_status};
        ADDR_W'(OFF_MASK):    bus_rdata <= {{SRC_PAD{1'b0}}, irq_enable};
        ADDR_W'(OFF_CTRL): begin
          bus_rdata                <= '0;
          bus_rdata[CTRL_BATT_BIT] <= ctrl_batt;
          bus_rdata[CTRL_OSC_BIT]  <= ctrl_osc;
        end
        default:              bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/rtc_sec_core_chk.sv
`timescale 1ns/1ps
module rtc_sec_core_chk #(
  parameter int ADDR_W = 7,
  parameter int TICK_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              sec_pulse,
  input logic              load_pend,
  input logic              alarm_hit,
  input logic [31:0]       cur_sec,
  input logic [TICK_W-1:0] tick_cnt,
  input logic [TICK_W-1:0] cal,
  input logic [1:0]        status,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              clr_alm_bit,
  input logic              irq_sec,
  input logic              irq_alarm
);
  import rtc_pkg::*;

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !sec_pulse |=> cur_sec == $past(cur_sec));

  p_step_r3: assert property (@(posedge clk) disable iff (rst)
    (sec_pulse && !load_pend) |=> cur_sec == $past(cur_sec) + 32'd1);

  p_tick_bound_r4: assert property (@(posedge clk) disable iff (rst)
    tick_cnt <= cal);

  p_cal_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(OFF_CAL_WR)) |=> tick_cnt == '0);

  p_sec_flag_r6: assert property (@(posedge clk) disable iff (rst)
    sec_pulse |=> status[0]);

  p_alarm_flag_r10: assert property (@(posedge clk) disable iff (rst)
    alarm_hit |=> status[1]);

  p_w1c_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(OFF_STATUS) && clr_alm_bit && !alarm_hit)
      |=> !status[1]);

  p_irq_src_r9: assert property (@(posedge clk) disable iff (rst)
    (irq_sec |-> status[0]) and (irq_alarm |-> status[1]));
endmodule

bind rtc_sec_core rtc_sec_core_chk #(.ADDR_W(ADDR_W), .TICK_W(TICK_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .sec_pulse   (sec_pulse),
  .load_pend   (load_pend),
  .alarm_hit   (alarm_hit),
  .cur_sec     (cur_sec),
  .tick_cnt    (tick_cnt),
  .cal         (cal_val),
  .status      (irq_status),
  .bus_wr      (bus_wr),
  .bus_addr    (bus_addr),
  .clr_alm_bit (bus_wdata[1]),
  .irq_sec     (irq_sec),
  .irq_alarm   (irq_alarm)
);

// File: tb/rtc_sec_core_test.sv
`timescale 1ns/1ps
module rtc_sec_core_test;
  localparam int ADDR_W = 7;
  localparam int CAL0   = 3;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              tick_en = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic              bus_wr = 1'b0;
  logic              bus_rd = 1'b0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic              irq_sec, irq_alarm;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int last_edge = 0;
  bit done = 0;

  rtc_sec_core #(.ADDR_W(ADDR_W), .TICK_W(16), .CAL_RESET(CAL0)) uut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_sec(irq_sec), .irq_alarm(irq_alarm)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic wr(input int addr, input logic [31:0] data);
    @(negedge clk);
    bus_addr = ADDR_W'(addr); bus_wdata = data; bus_wr = 1'b1;
    @(negedge clk);
    last_edge = cyc;
    bus_wr = 1'b0;
  endtask

  // returns data and the edge number at which it was captured
  task automatic rd(input int addr, output logic [31:0] data, output int q);
    @(negedge clk);
    bus_addr = ADDR_W'(addr); bus_rd = 1'b1;
    @(negedge clk);
    data = bus_rdata; q = cyc;
    bus_rd = 1'b0;
  endtask

  task automatic stop_ticks();
    @(negedge clk);
    tick_en = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // one timed scenario: load time s, start the second with cal n, follow it
  task automatic run_second(input int n, input logic [31:0] s);
    logic [31:0] v, old, exp;
    int q, p0, k;
    stop_ticks();
    rd('h10, old, q);
    wr('h20, 32'h1);
    wr('h00, s);
    rd('h10, v, q);  chk("R2 current time unchanged before boundary", v, old);
    rd('h04, v, q);  chk("R2 set-time readback", v, s);
    rd('h20, v, q);  chk("R2 seconds status still clear", v & 32'h1, 32'h0);
    wr('h08, 32'(n));
    p0 = last_edge;
    tick_en = 1'b1;
    rd('h0C, v, q);  chk("R1 calibration readback", v, 32'(n));
    for (int i = 0; i < 3 * (n + 1) + 6; i++) begin
      rd('h14, v, q);
      k = q - 1 - p0;
      chk("R4/R5 tick count", v, 32'(k % (n + 1)));
      rd('h10, v, q);
      k = q - 1 - p0;
      if (k >= n + 2) begin
        exp = s + 32'((k - 1) / (n + 1)) - 32'd1;
        chk("R3 seconds count incl wrap / R2 load at boundary", v, exp);
      end
    end
    rd('h20, v, q);  chk("R6 seconds status set", v & 32'h1, 32'h1);
  endtask

  initial begin
    logic [31:0] v;
    int q, p0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R12 reset state
    rd('h10, v, q); chk("R12 seconds after reset", v, 32'h0);
    rd('h20, v, q); chk("R12 status after reset", v, 32'h0);
    rd('h24, v, q); chk("R12 mask after reset", v, 32'h0);
    rd('h40, v, q); chk("R12 control after reset", v, 32'h0);
    rd('h0C, v, q); chk("R12 calibration after reset", v, 32'(CAL0));
    rd('h14, v, q); chk("R12 tick after reset", v, 32'h0);
    chk("R12 irq outputs after reset", {30'h0, irq_alarm, irq_sec}, 32'h0);

    // R1 alarm read/write, unmapped offset, write-only offsets read 0
    wr('h18, 32'hA5A5_0F0F);
    rd('h18, v, q); chk("R1 alarm readback", v, 32'hA5A5_0F0F);
    rd('h1C, v, q); chk("R1 unmapped offset reads zero", v, 32'h0);
    rd('h28, v, q); chk("R1 enable offset reads zero", v, 32'h0);

    // R11 control bits
    wr('h40, 32'hFFFF_FFFF);
    rd('h40, v, q); chk("R11 control only bits 31 and 24", v, 32'h8100_0000);
    wr('h40, 32'h0100_0000);
    rd('h40, v, q); chk("R11 control oscillator bit alone", v, 32'h0100_0000);

    // R2..R6 sweep of calibration values and start times (wrap included)
    run_second(0, 32'h0000_0000);
    run_second(1, 32'hFFFF_FFFE);
    run_second(2, 32'h1234_5678);
    run_second(3, 32'hFFFF_FFFF);
    run_second(4, 32'd100);

    // R8 enable/disable/mask
    wr('h28, 32'h3);
    rd('h24, v, q); chk("R8 mask after enabling both", v, 32'h3);
    wr('h2C, 32'h1);
    rd('h24, v, q); chk("R8 mask after disabling seconds", v, 32'h2);
    wr('h2C, 32'h2);
    rd('h24, v, q); chk("R8 mask after disabling alarm", v, 32'h0);

    // R10 alarm timing with R9 gating
    stop_ticks();
    wr('h20, 32'h3);
    wr('h00, 32'd50);
    wr('h18, 32'd52);
    wr('h28, 32'h2);
    wr('h08, 32'd2);
    p0 = last_edge;
    tick_en = 1'b1;
    while (cyc < p0 + 3 * 2 + 3) @(negedge clk);
    chk("R10 alarm not yet raised one cycle early", {31'h0, irq_alarm}, 32'h0);
    @(negedge clk);
    chk("R10 alarm raised at matching update", {31'h0, irq_alarm}, 32'h1);
    chk("R9 seconds irq low while not enabled", {31'h0, irq_sec}, 32'h0);
    rd('h20, v, q); chk("R6 both status bits set", v, 32'h3);
    wr('h2C, 32'h2);
    @(negedge clk);
    chk("R9 alarm irq low after disable", {31'h0, irq_alarm}, 32'h0);
    rd('h20, v, q); chk("R6 alarm status kept without enable", v & 32'h2, 32'h2);
    wr('h20, 32'h2);
    rd('h20, v, q); chk("R7 alarm status cleared by write-1", v & 32'h2, 32'h0);
    wr('h28, 32'h1);
    chk("R9 seconds irq follows pending status on enable", {31'h0, irq_sec}, 32'h1);

    // R7 writing zero leaves status
    stop_ticks();
    wr('h20, 32'h0);
    rd('h20, v, q); chk("R7 zero write keeps seconds status", v & 32'h1, 32'h1);
    wr('h20, 32'h1);
    rd('h20, v, q); chk("R7 seconds status cleared", v & 32'h1, 32'h0);
    chk("R9 seconds irq drops with status", {31'h0, irq_sec}, 32'h0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule